// File: doc/BRIEF.md
# Accumulator ALU with Flag Write Mask

This block is the arithmetic and logic stage of a small accumulator-based processor. Each cycle it takes an operation code, a register operand, a memory or immediate operand and the incoming carry. One clock edge later it presents the result, four status flags (negative, overflow, zero, carry), a result write enable and a four-bit flag write mask. The surrounding datapath uses the write enable to decide whether the accumulator or memory is written. It uses the mask to decide which bits of its status register take the new flag values.

All the arithmetic shares one adder: add, subtract, compare, increment and decrement. Subtraction adds the one's complement of the memory operand, so a set carry in means "no borrow". Compare and bit test only produce flags, and their result write enable stays low. Decimal arithmetic, the register file and instruction sequencing are not part of this block.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low, every output is 0. Reset acts asynchronously and also clears the outputs in the middle of a run.
- R2: The outputs show the operation and operands sampled at the previous rising clock edge, one cycle of latency. Inputs that change between edges do not alter the outputs until the next edge.
- R3: Op code 0 (add) gives result = A + M + Cin modulo 2^WIDTH. C is the carry out. V is set when A and M have the same sign and the result sign differs. Mask = 1111.
- R4: Op code 1 (subtract) gives result = A - M - (1 - Cin), computed as A + ~M + Cin. C = 1 means no borrow. V follows the R3 rule with ~M as the second operand. Mask = 1111.
- R5: Op codes 2, 3 and 4 give A AND M, A OR M and A XOR M. Mask = 1010.
- R6: Op code 5 (shift left) moves the top bit into C and fills bit 0 with 0. Op code 6 (logical shift right) moves bit 0 into C and fills the top bit with 0. Mask = 1011.
- R7: Op code 7 (rotate left) puts Cin into bit 0 and the old top bit into C. Op code 8 (rotate right) puts Cin into the top bit and the old bit 0 into C. Mask = 1011.
- R8: Op codes 9 and 10 give A + 1 and A - 1, wrapping modulo 2^WIDTH. Cin has no effect. Mask = 1010, so C and V stay untouched.
- R9: Op code 11 (compare) forms A - M. C = 1 when A >= M unsigned. Z = 1 when A = M. N is the top bit of the difference. Mask = 1011 and the result write enable is 0.
- R10: Op code 12 (bit test) sets Z when (A AND M) is zero, N from the top bit of M and V from the bit below it. Mask = 1110 and the result write enable is 0.
- R11: For op codes 0 to 10 the result write enable is 1, N equals the result's top bit, and Z is 1 exactly when the result is zero.
- R12: Op codes 13 to 15 produce result 0, write enable 0, mask 0000 and all flags 0.
- R13: Mask bit 3 is N, bit 2 is V, bit 1 is Z and bit 0 is C. A flag whose mask bit is 0 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code (0 to 15) |
| a_i | input | WIDTH | Register operand |
| m_i | input | WIDTH | Memory or immediate operand |
| c_i | input | 1 | Incoming carry flag |
| res_q | output | WIDTH | Registered result |
| res_we_q | output | 1 | Result should be written back |
| n_q | output | 1 | Negative flag |
| v_q | output | 1 | Overflow flag |
| z_q | output | 1 | Zero flag |
| c_q | output | 1 | Carry flag |
| flag_mask_q | output | 4 | Flag write mask {N,V,Z,C} |

## Verification
The bench builds the block with its default WIDTH of 8. At that width the hand-computed vectors can sit exactly on the signed boundaries 0x7F/0x80 and the unsigned wrap at 0xFF/0x00, where overflow, carry and zero all change together. With an 8-bit operand space, an integer sweep of the add and subtract paths also covers a spread of both signs and carries within a few hundred cycles.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_SHL = 4'd5,
        OP_SHR = 4'd6,
        OP_ROL = 4'd7,
        OP_ROR = 4'd8,
        OP_INC = 4'd9,
        OP_DEC = 4'd10,
        OP_CMP = 4'd11,
        OP_BIT = 4'd12
    } alu_op_e;

    localparam int FLAG_N = 3;
    localparam int FLAG_V = 2;
    localparam int FLAG_Z = 1;
    localparam int FLAG_C = 0;
    localparam int NUM_FLAGS = 4;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;

    localparam flag_vec_t MASK_ALL   = 4'b1111;
    localparam flag_vec_t MASK_NZ    = 4'b1010;
    localparam flag_vec_t MASK_NZC   = 4'b1011;
    localparam flag_vec_t MASK_NVZ   = 4'b1110;
    localparam flag_vec_t MASK_NONE  = 4'b0000;

endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             ci_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             co_o,
    output logic             ovf_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] total;

    assign total = {1'b0, a_i} + {1'b0, b_i} + (WIDTH+1)'(ci_i);
    assign sum_o = total[WIDTH-1:0];
    assign co_o  = total[WIDTH];
    // Same-sign operands giving a different-sign sum means signed overflow
    assign ovf_o = (a_i[MSB] == b_i[MSB]) && (sum_o[MSB] != a_i[MSB]);

endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e          op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic             ci_i,
    output logic [WIDTH-1:0] res_o,
    output logic             co_o
);
    localparam int MSB = WIDTH - 1;

    always_comb begin
        res_o = a_i;
        co_o  = ci_i;
        case (op_i)
            OP_SHL: begin
                res_o = {a_i[MSB-1:0], 1'b0};
                co_o  = a_i[MSB];
            end
            OP_SHR: begin
                res_o = {1'b0, a_i[MSB:1]};
                co_o  = a_i[0];
            end
            OP_ROL: begin
                res_o = {a_i[MSB-1:0], ci_i};
                co_o  = a_i[MSB];
            end
            OP_ROR: begin
                res_o = {ci_i, a_i[MSB:1]};
                co_o  = a_i[0];
            end
            default: begin
                res_o = a_i;
                co_o  = ci_i;
            end
        endcase
    end

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e          op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] m_i,
    output logic [WIDTH-1:0] res_o
);
    logic sel_or;
    logic sel_xor;

    assign sel_or  = (op_i == OP_OR);
    assign sel_xor = (op_i == OP_XOR);

    // One bit slice per position; AND is the default so bit test can reuse it
    for (genvar k = 0; k < WIDTH; k++) begin : g_bit
        assign res_o[k] = sel_or  ? (a_i[k] | m_i[k]) :
                          sel_xor ? (a_i[k] ^ m_i[k]) :
                                    (a_i[k] & m_i[k]);
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] m_i,
    input  logic             c_i,
    output logic [WIDTH-1:0] res_q,
    output logic             res_we_q,
    output logic             n_q,
    output logic             v_q,
    output logic             z_q,
    output logic             c_q,
    output logic [3:0]       flag_mask_q
);
    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             we;
        flag_vec_t        flg;
        flag_vec_t        mask;
    } alu_state_t;

    alu_state_t state_d;
    alu_state_t state_q;

    alu_op_e op;
    assign op = alu_op_e'(op_i);

    // Shared adder operand selection
    logic [WIDTH-1:0] add_b;
    logic             add_ci;
    logic [WIDTH-1:0] add_sum;
    logic             add_co;
    logic             add_ovf;

    always_comb begin
        add_b  = m_i;
        add_ci = c_i;
        case (op)
            OP_SUB: begin add_b = ~m_i;           add_ci = c_i;  end
            OP_CMP: begin add_b = ~m_i;           add_ci = 1'b1; end
            OP_INC: begin add_b = '0;             add_ci = 1'b1; end
            OP_DEC: begin add_b = '1;             add_ci = 1'b0; end
            default: begin add_b = m_i;           add_ci = c_i;  end
        endcase
    end

    acc_alu_adder #(.WIDTH(WIDTH)) u_adder (
        .a_i   (a_i),
        .b_i   (add_b),
        .ci_i  (add_ci),
        .sum_o (add_sum),
        .co_o  (add_co),
        .ovf_o (add_ovf)
    );

    logic [WIDTH-1:0] sh_res;
    logic             sh_co;

    acc_alu_shift #(.WIDTH(WIDTH)) u_shift (
        .op_i  (op),
        .a_i   (a_i),
        .ci_i  (c_i),
        .res_o (sh_res),
        .co_o  (sh_co)
    );

    logic [WIDTH-1:0] lg_res;

    acc_alu_logic #(.WIDTH(WIDTH)) u_logic (
        .op_i  (op),
        .a_i   (a_i),
        .m_i   (m_i),
        .res_o (lg_res)
    );

    always_comb begin
        state_d = '0;
        case (op)
            OP_ADD, OP_SUB: begin
                state_d.res         = add_sum;
                state_d.we          = 1'b1;
                state_d.mask        = MASK_ALL;
                state_d.flg[FLAG_C] = add_co;
                state_d.flg[FLAG_V] = add_ovf;
            end
            OP_AND, OP_OR, OP_XOR: begin
                state_d.res  = lg_res;
                state_d.we   = 1'b1;
                state_d.mask = MASK_NZ;
            end
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                state_d.res         = sh_res;
                state_d.we          = 1'b1;
                state_d.mask        = MASK_NZC;
                state_d.flg[FLAG_C] = sh_co;
            end
            OP_INC, OP_DEC: begin
                state_d.res  = add_sum;
                state_d.we   = 1'b1;
                state_d.mask = MASK_NZ;
            end
            OP_CMP: begin
                state_d.res         = add_sum;
                state_d.mask        = MASK_NZC;
                state_d.flg[FLAG_C] = add_co;
            end
            OP_BIT: begin
                state_d.res         = lg_res;
                state_d.mask        = MASK_NVZ;
                state_d.flg[FLAG_N] = m_i[MSB];
                state_d.flg[FLAG_V] = m_i[MSB-1];
            end
            default: begin
                state_d = '0;
            end
        endcase

        // Sign and zero come from the result for every op that updates them,
        // except bit test, whose N is taken from the memory operand
        if (state_d.mask[FLAG_N] && (op != OP_BIT)) begin
            state_d.flg[FLAG_N] = state_d.res[MSB];
        end
        if (state_d.mask[FLAG_Z]) begin
            state_d.flg[FLAG_Z] = (state_d.res == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign res_q       = state_q.res;
    assign res_we_q    = state_q.we;
    assign n_q         = state_q.flg[FLAG_N];
    assign v_q         = state_q.flg[FLAG_V];
    assign z_q         = state_q.flg[FLAG_Z];
    assign c_q         = state_q.flg[FLAG_C];
    assign flag_mask_q = state_q.mask;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       op_i,
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] m_i,
    input logic             c_i,
    input logic [WIDTH-1:0] res_q,
    input logic             res_we_q,
    input logic             n_q,
    input logic             v_q,
    input logic             z_q,
    input logic             c_q,
    input logic [3:0]       flag_mask_q
);
    localparam int MSB = WIDTH - 1;

    // R11
    n_tracks_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we_q && flag_mask_q[FLAG_N]) |-> (n_q == res_q[MSB]));

    // R11
    z_tracks_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we_q && flag_mask_q[FLAG_Z]) |-> (z_q == (res_q == '0)));

    // R8
    incdec_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_INC || op_i == OP_DEC) |=> (flag_mask_q == 4'b1010 && res_we_q));

    // R9
    flags_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CMP || op_i == OP_BIT) |=> !res_we_q);

    // R6
    shl_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SHL) |=> (c_q == $past(a_i[MSB]) && res_q[0] == 1'b0));

    // R7
    rol_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ROL) |=> (res_q[0] == $past(c_i)));

    // R10
    bit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_BIT) |=> (n_q == $past(m_i[MSB]) && v_q == $past(m_i[MSB-1])));

    // R12
    unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i > OP_BIT) |=> (flag_mask_q == 4'b0000 && !res_we_q && !z_q));

endmodule

bind acc_alu acc_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_i        (op_i),
    .a_i         (a_i),
    .m_i         (m_i),
    .c_i         (c_i),
    .res_q       (res_q),
    .res_we_q    (res_we_q),
    .n_q         (n_q),
    .v_q         (v_q),
    .z_q         (z_q),
    .c_q         (c_q),
    .flag_mask_q (flag_mask_q)
);

// File: tb/acc_alu_test.sv
module acc_alu_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int NVEC = 24;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   op_i = '0;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] m_i = '0;
    logic         c_i = 1'b0;
    logic [W-1:0] res_q;
    logic         res_we_q, n_q, v_q, z_q, c_q;
    logic [3:0]   flag_mask_q;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_alu #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .m_i(m_i), .c_i(c_i),
        .res_q(res_q), .res_we_q(res_we_q), .n_q(n_q), .v_q(v_q), .z_q(z_q),
        .c_q(c_q), .flag_mask_q(flag_mask_q)
    );

    // {op, a, m, cin, res, we, flags NVZC, mask NVZC}
    localparam logic [37:0] VECS [0:NVEC-1] = '{
        {4'd0,  8'h50, 8'h50, 1'b0, 8'hA0, 1'b1, 4'b1100, 4'b1111},
        {4'd0,  8'hFF, 8'h01, 1'b0, 8'h00, 1'b1, 4'b0011, 4'b1111},
        {4'd0,  8'h10, 8'h20, 1'b1, 8'h31, 1'b1, 4'b0000, 4'b1111},
        {4'd1,  8'h50, 8'h10, 1'b1, 8'h40, 1'b1, 4'b0001, 4'b1111},
        {4'd1,  8'h00, 8'h01, 1'b1, 8'hFF, 1'b1, 4'b1000, 4'b1111},
        {4'd1,  8'h80, 8'h01, 1'b1, 8'h7F, 1'b1, 4'b0101, 4'b1111},
        {4'd1,  8'h05, 8'h05, 1'b0, 8'hFF, 1'b1, 4'b1000, 4'b1111},
        {4'd2,  8'hF0, 8'h3C, 1'b1, 8'h30, 1'b1, 4'b0000, 4'b1010},
        {4'd3,  8'h00, 8'h00, 1'b0, 8'h00, 1'b1, 4'b0010, 4'b1010},
        {4'd4,  8'hFF, 8'h7F, 1'b0, 8'h80, 1'b1, 4'b1000, 4'b1010},
        {4'd5,  8'h81, 8'h00, 1'b1, 8'h02, 1'b1, 4'b0001, 4'b1011},
        {4'd6,  8'h01, 8'h00, 1'b0, 8'h00, 1'b1, 4'b0011, 4'b1011},
        {4'd7,  8'h80, 8'h00, 1'b1, 8'h01, 1'b1, 4'b0001, 4'b1011},
        {4'd8,  8'h01, 8'h00, 1'b1, 8'h80, 1'b1, 4'b1001, 4'b1011},
        {4'd8,  8'h02, 8'h00, 1'b0, 8'h01, 1'b1, 4'b0000, 4'b1011},
        {4'd9,  8'hFF, 8'h00, 1'b1, 8'h00, 1'b1, 4'b0010, 4'b1010},
        {4'd10, 8'h00, 8'h00, 1'b1, 8'hFF, 1'b1, 4'b1000, 4'b1010},
        {4'd11, 8'h10, 8'h20, 1'b0, 8'hF0, 1'b0, 4'b1000, 4'b1011},
        {4'd11, 8'h42, 8'h42, 1'b0, 8'h00, 1'b0, 4'b0011, 4'b1011},
        {4'd11, 8'h30, 8'h10, 1'b0, 8'h20, 1'b0, 4'b0001, 4'b1011},
        {4'd12, 8'h0F, 8'hC0, 1'b0, 8'h00, 1'b0, 4'b1110, 4'b1110},
        {4'd12, 8'hFF, 8'h01, 1'b1, 8'h01, 1'b0, 4'b0000, 4'b1110},
        {4'd13, 8'h55, 8'hAA, 1'b1, 8'h00, 1'b0, 4'b0000, 4'b0000},
        {4'd15, 8'hFF, 8'hFF, 1'b1, 8'h00, 1'b0, 4'b0000, 4'b0000}
    };

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0:                   return "R3";
            4'd1:                   return "R4";
            4'd2, 4'd3, 4'd4:       return "R5";
            4'd5, 4'd6:             return "R6";
            4'd7, 4'd8:             return "R7";
            4'd9, 4'd10:            return "R8";
            4'd11:                  return "R9";
            4'd12:                  return "R10";
            default:                return "R12";
        endcase
    endfunction

    function automatic logic [16:0] observed();
        return {res_q, res_we_q, n_q, v_q, z_q, c_q, flag_mask_q};
    endfunction

    task automatic check(input string req, input logic [16:0] exp);
        n_chk++;
        if (observed() !== exp) begin
            n_bad++;
            $display("FAIL %s: actual res=%h we=%b nvzc=%b mask=%b, expected res=%h we=%b nvzc=%b mask=%b",
                     req, res_q, res_we_q, {n_q, v_q, z_q, c_q}, flag_mask_q,
                     exp[16:9], exp[8], exp[7:4], exp[3:0]);
        end
    endtask

    task automatic apply(input logic [3:0] op, input logic [W-1:0] a,
                         input logic [W-1:0] m, input logic ci);
        @(negedge clk);
        op_i = op; a_i = a; m_i = m; c_i = ci;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        check("R1", 17'h0);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i][37:34], VECS[i][33:26], VECS[i][25:18], VECS[i][17]);
            check(req_of(VECS[i][37:34]), VECS[i][16:0]);
        end

        // R11 / R13: rule sweep for add and subtract
        for (int i = 0; i < 256; i += 17) begin
            for (int j = 0; j < 256; j += 29) begin
                for (int s = 0; s < 2; s++) begin
                    int cin, sa, sm, raw, sraw;
                    logic [W-1:0] r;
                    logic cf, vf;
                    cin = (i + j) % 2;
                    sa = (i >= 128) ? i - 256 : i;
                    sm = (j >= 128) ? j - 256 : j;
                    if (s == 0) begin
                        raw = i + j + cin;
                        sraw = sa + sm + cin;
                        cf = (raw > 255);
                    end else begin
                        raw = i - j - (1 - cin);
                        sraw = sa - sm - (1 - cin);
                        cf = (raw >= 0);
                    end
                    r = W'(raw & 255);
                    vf = (sraw > 127) || (sraw < -128);
                    apply(4'(s), W'(i), W'(j), cin[0]);
                    check((s == 0) ? "R3 R11 R13" : "R4 R11 R13",
                          {r, 1'b1, r[W-1], vf, (r == '0), cf, 4'b1111});
                end
            end
        end

        // R2: mid-cycle input change is not seen until the next edge
        apply(4'd0, 8'h01, 8'h02, 1'b0);
        op_i = 4'd4; a_i = 8'hFF; m_i = 8'h0F;
        #1;
        check("R2", {8'h03, 1'b1, 4'b0000, 4'b1111});
        @(posedge clk);
        @(negedge clk);
        check("R2", {8'hF0, 1'b1, 4'b1000, 4'b1010});

        // R8: carry in has no effect on increment
        apply(4'd9, 8'h7F, 8'h00, 1'b0);
        check("R8", {8'h80, 1'b1, 4'b1000, 4'b1010});
        apply(4'd9, 8'h7F, 8'h00, 1'b1);
        check("R8", {8'h80, 1'b1, 4'b1000, 4'b1010});

        // R1: asynchronous reset mid-run
        apply(4'd0, 8'h50, 8'h50, 1'b0);
        #1 rst_n = 1'b0;
        #1;
        check("R1", 17'h0);
        @(negedge clk);
        check("R1", 17'h0);
        rst_n = 1'b1;
        apply(4'd11, 8'h80, 8'h7F, 1'b0);
        check("R9", {8'h01, 1'b0, 4'b0001, 4'b1011});

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule